// File: doc/BRIEF.md
# Supervisory Reset Timing Controller

This block turns the digitized flags of a supply supervisor into a system reset and an early warning. It watches a supply-low flag and a push-button manual reset pin. Reset is held for as long as either cause is present. It is then held for a programmable hold-off time after both causes have gone away. The hold-off is measured in ticks of a slow reference clock, and a two-bit select picks one of four lengths.

The manual reset pin is synchronized and debounced inside the block. A warning output follows the supply-low flag with no delay at all, so firmware can act before the delayed reset lands. The polarity of the reset output is fixed at build time. Comparators, threshold generation and pad drivers live outside this block.

Top module: `supv_reset_ctrl`

## Requirements
- R1: While `rst_n` is low, `sys_rst` is asserted. After `rst_n` rises with no cause present, reset stays asserted until the supply has been good for a full hold-off. With a tick on every clock and select 0, it releases on the 51st rising clock edge.
- R2: When `supply_low` is seen high at a clock edge, `sys_rst` is asserted after that edge.
- R3: The hold-off is TMO_0, TMO_1, TMO_2 or TMO_3 ticks for `tmo_sel` = 0, 1, 2 or 3 (defaults 50, 200, 400, 800). With a tick on every clock, reset releases TMO+1 edges after the cause clears: one edge to start timing, then one edge per tick.
- R4: The hold-off counter advances only on clocks where `tick` is high. Without ticks, reset stays asserted indefinitely.
- R5: `mr_n` counts as pressed only after its synchronized value has stayed low for DEB_TICKS (16) consecutive ticks. From the edge where `mr_n` first reads low to reset assertion is 19 edges. A low pulse shorter than 16 ticks has no effect on `sys_rst`.
- R6: After `mr_n` is released, reset is held through the debounce time and then a full hold-off. With select 0, that is 69 edges in total.
- R7: A new cause seen during the hold-off returns the block to hold, and the count restarts from zero once the cause clears.
- R8: `tmo_sel` is sampled when the hold-off starts. A change during a running hold-off does not alter its length.
- R9: `warn_n` equals the inverse of `supply_low` at all times, with no clock delay.
- R10: With ACTIVE_HIGH=1, `sys_rst` is high while reset is active. With ACTIVE_HIGH=0, it is low while reset is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| supply_low | input | 1 | Digitized supply-below-threshold flag, synchronous to clk |
| mr_n | input | 1 | Asynchronous manual reset pin, low = pressed |
| tmo_sel | input | 2 | Hold-off length select |
| tick | input | 1 | One-clock pulse from the slow reference clock |
| sys_rst | output | 1 | System reset, polarity set by ACTIVE_HIGH |
| warn_n | output | 1 | Undelayed low-supply warning, low = supply low |

## Verification
A debounce counter that miscounts shows up at `sys_rst` in one of two ways. It either asserts reset for a short press, or it shifts the press-to-assert delay away from 19 edges. Either fault is visible within about twenty clocks of the pin change.

A hold-off counter that does not clear on a new cause, or that mishandles the tick enable, shows up as a release edge off by the elapsed count. A select latched at the wrong time gives a hold-off of the wrong length. These errors surface at release time, at most 801 edges after the cause clears.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [1:0] {
    ST_HOLD = 2'd0,
    ST_TIME = 2'd1,
    ST_RUN  = 2'd2
  } supv_state_e;
endpackage

// File: rtl/supv_mr_filter.sv
module supv_mr_filter #(
  parameter int unsigned DEB_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin_n,
  output logic pressed
);
  localparam int unsigned DW = $clog2(DEB_TICKS + 1);

  logic          sync1_q, sync2_q;
  logic          level_q, level_nx;
  logic [DW-1:0] cnt_q, cnt_nx;

  // two-stage synchronizer, idle level is released (high)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= 1'b1;
      sync2_q <= 1'b1;
    end else begin
      sync1_q <= pin_n;
      sync2_q <= sync1_q;
    end
  end

  // debounced level follows the synced pin only after DEB_TICKS stable ticks
  always_comb begin
    level_nx = level_q;
    cnt_nx   = cnt_q;
    if (sync2_q == level_q) begin
      cnt_nx = '0;
    end else if (tick) begin
      if (cnt_q == DW'(DEB_TICKS - 1)) begin
        level_nx = sync2_q;
        cnt_nx   = '0;
      end else begin
        cnt_nx = cnt_q + DW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b1;
      cnt_q   <= '0;
    end else begin
      level_q <= level_nx;
      cnt_q   <= cnt_nx;
    end
  end

  assign pressed = ~level_q;
endmodule

// File: rtl/supv_rst_timer.sv
module supv_rst_timer
  import supv_pkg::*;
#(
  parameter int unsigned TMO_0 = 50,
  parameter int unsigned TMO_1 = 200,
  parameter int unsigned TMO_2 = 400,
  parameter int unsigned TMO_3 = 800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cause,
  input  logic       tick,
  input  logic [1:0] sel,
  output logic       active
);
  localparam int unsigned MAX01 = (TMO_0 > TMO_1) ? TMO_0 : TMO_1;
  localparam int unsigned MAX23 = (TMO_2 > TMO_3) ? TMO_2 : TMO_3;
  localparam int unsigned TMAX  = (MAX01 > MAX23) ? MAX01 : MAX23;
  localparam int unsigned CW    = $clog2(TMAX + 1);

  supv_state_e   state_q, state_nx;
  logic [CW-1:0] cnt_q, cnt_nx;
  logic [CW-1:0] lim_q, lim_nx;
  logic [CW-1:0] sel_lim;

  always_comb begin
    case (sel)
      2'd0:    sel_lim = CW'(TMO_0);
      2'd1:    sel_lim = CW'(TMO_1);
      2'd2:    sel_lim = CW'(TMO_2);
      default: sel_lim = CW'(TMO_3);
    endcase
  end

  always_comb begin
    state_nx = state_q;
    cnt_nx   = cnt_q;
    lim_nx   = lim_q;
    unique case (state_q)
      ST_HOLD: begin
        if (!cause) begin
          state_nx = ST_TIME;
          cnt_nx   = '0;
          lim_nx   = sel_lim;
        end
      end
      ST_TIME: begin
        if (cause) begin
          state_nx = ST_HOLD;
          cnt_nx   = '0;
        end else if (tick) begin
          if (cnt_q == lim_q - CW'(1)) begin
            state_nx = ST_RUN;
            cnt_nx   = '0;
          end else begin
            cnt_nx = cnt_q + CW'(1);
          end
        end
      end
      ST_RUN: begin
        if (cause) state_nx = ST_HOLD;
      end
      default: state_nx = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
      lim_q   <= '0;
    end else begin
      state_q <= state_nx;
      cnt_q   <= cnt_nx;
      lim_q   <= lim_nx;
    end
  end

  assign active = (state_q != ST_RUN);
endmodule

// File: rtl/supv_reset_ctrl.sv
module supv_reset_ctrl #(
  parameter bit          ACTIVE_HIGH = 1'b1,
  parameter int unsigned DEB_TICKS   = 16,
  parameter int unsigned TMO_0       = 50,
  parameter int unsigned TMO_1       = 200,
  parameter int unsigned TMO_2       = 400,
  parameter int unsigned TMO_3       = 800
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_low,
  input  logic       mr_n,
  input  logic [1:0] tmo_sel,
  input  logic       tick,
  output logic       sys_rst,
  output logic       warn_n
);
  logic mr_pressed;
  logic rst_act;

  supv_mr_filter #(.DEB_TICKS(DEB_TICKS)) u_mr (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .pin_n   (mr_n),
    .pressed (mr_pressed)
  );

  supv_rst_timer #(
    .TMO_0(TMO_0), .TMO_1(TMO_1), .TMO_2(TMO_2), .TMO_3(TMO_3)
  ) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .cause  (supply_low | mr_pressed),
    .tick   (tick),
    .sel    (tmo_sel),
    .active (rst_act)
  );

  generate
    if (ACTIVE_HIGH) begin : g_pol_hi
      assign sys_rst = rst_act;
    end else begin : g_pol_lo
      assign sys_rst = ~rst_act;
    end
  endgenerate

  assign warn_n = ~supply_low;
endmodule

// File: rtl/supv_reset_chk.sv
module supv_reset_chk #(
  parameter bit          ACTIVE_HIGH = 1'b1,
  parameter int unsigned TMO_MIN     = 50
) (
  input logic clk,
  input logic rst_n,
  input logic supply_low,
  input logic tick,
  input logic sys_rst,
  input logic warn_n
);
  logic        act;
  logic [15:0] good_cnt;

  assign act = (sys_rst == ACTIVE_HIGH);

  // clocks since supply_low was last seen high, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               good_cnt <= '0;
    else if (supply_low)      good_cnt <= '0;
    else if (good_cnt != '1)  good_cnt <= good_cnt + 16'd1;
  end

  p_supply_r2: assert property (@(posedge clk) disable iff (!rst_n)
    supply_low |=> act);

  p_warn_r9: assert property (@(posedge clk) disable iff (!rst_n)
    warn_n == !supply_low);

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act) |-> !$past(supply_low));

  p_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act) |-> $past(tick));

  p_min_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(act) |-> (good_cnt >= 16'(TMO_MIN)));
endmodule

bind supv_reset_ctrl supv_reset_chk #(
  .ACTIVE_HIGH (ACTIVE_HIGH),
  .TMO_MIN     (TMO_0)
) u_chk (.*);

// File: tb/supv_reset_ctrl_test.sv
module supv_reset_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       supply_low;
  logic       mr_n;
  logic [1:0] tmo_sel;
  logic       tick;
  logic       sys_rst, warn_n;
  logic       sys_rst_lo, warn_n_lo;

  int total = 0;
  int bad   = 0;

  always #5ns clk = ~clk;

  supv_reset_ctrl uut (
    .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .mr_n(mr_n),
    .tmo_sel(tmo_sel), .tick(tick), .sys_rst(sys_rst), .warn_n(warn_n)
  );

  supv_reset_ctrl #(.ACTIVE_HIGH(1'b0)) uut_lo (
    .clk(clk), .rst_n(rst_n), .supply_low(supply_low), .mr_n(mr_n),
    .tmo_sel(tmo_sel), .tick(tick), .sys_rst(sys_rst_lo), .warn_n(warn_n_lo)
  );

  // {select, expected edges from cause clear to release}
  localparam int NVEC = 4;
  localparam int VEC [NVEC][2] = '{'{0, 51}, '{1, 201}, '{2, 401}, '{3, 801}};

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // counts falling edges until reset releases (sys_rst goes low)
  task automatic measure(output int n);
    n = 0;
    while (sys_rst && n < 3000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pulse_supply();
    supply_low = 1'b1;
    step(1);
    supply_low = 1'b0;
  endtask

  initial begin
    #3ms;
    bad++;
    total++;
    $display("FAIL all requirements: watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    int viol;
    rst_n = 1'b0; supply_low = 1'b0; mr_n = 1'b1; tmo_sel = 2'd0; tick = 1'b1;
    step(3);
    chk("R1 reset state sys_rst", int'(sys_rst), 1);
    chk("R10 reset state low-polarity sys_rst", int'(sys_rst_lo), 0);
    chk("R9 reset state warn_n", int'(warn_n), 1);

    // R1: power-up hold-off
    rst_n = 1'b1;
    measure(n);
    chk("R1 power-up release edges", n, 51);

    // table walk: R2, R3, R9, R10 per select value
    for (int i = 0; i < NVEC; i++) begin
      supply_low = 1'b1;
      #1ns;
      chk("R9 warn_n low with supply_low", int'(warn_n), 0);
      tmo_sel = VEC[i][0][1:0];
      step(1);
      chk("R2 reset after supply_low", int'(sys_rst), 1);
      chk("R10 low polarity while active", int'(sys_rst_lo), 0);
      step(2);
      supply_low = 1'b0;
      #1ns;
      chk("R9 warn_n high after clear", int'(warn_n), 1);
      measure(n);
      chk("R3 hold-off edges", n, VEC[i][1]);
      chk("R10 low polarity after release", int'(sys_rst_lo), 1);
    end

    // R4: no ticks, no progress
    tmo_sel = 2'd0;
    pulse_supply();
    tick = 1'b0;
    step(1000);
    chk("R4 held without ticks", int'(sys_rst), 1);
    tick = 1'b1;
    measure(n);
    chk("R4 ticks resumed release edges", n, 50);

    // R7: new cause mid hold-off restarts count
    pulse_supply();
    step(30);
    pulse_supply();
    chk("R7 reset still active after restart cause", int'(sys_rst), 1);
    measure(n);
    chk("R7 restarted hold-off edges", n, 51);

    // R8: select change during hold-off ignored
    tmo_sel = 2'd0;
    pulse_supply();
    step(5);
    tmo_sel = 2'd3;
    measure(n);
    chk("R8 hold-off keeps sampled length", n + 5, 51);
    tmo_sel = 2'd0;

    // R5: short manual press ignored
    step(2);
    mr_n = 1'b0;
    step(10);
    mr_n = 1'b1;
    viol = 0;
    for (int k = 0; k < 40; k++) begin
      step(1);
      if (sys_rst) viol++;
    end
    chk("R5 short press cycles with reset", viol, 0);

    // R5: long press asserts after 19 edges
    mr_n = 1'b0;
    n = 0;
    while (!sys_rst && n < 100) begin
      step(1);
      n++;
    end
    chk("R5 press to assert edges", n, 19);
    step(30);

    // R6: release through debounce plus hold-off
    mr_n = 1'b1;
    measure(n);
    chk("R6 manual release to deassert edges", n, 69);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule